// File: doc/BRIEF.md
# DMA Channel Address Stepper

This block keeps the running source and destination addresses of one DMA channel, together with the channel's 32-bit control register that holds the two address modes. Each time the surrounding engine finishes one transfer unit, it pulses `step`. Both addresses then move by an amount set by three things: the programmed address modes, the transfer-size code, and the single-address-mode and direction flags.

Software or the engine seeds the addresses through two direct load ports. It programs the modes through a plain register write port. The current addresses and the control register contents are always visible on the outputs. The block has no data stream, so every pin is a plain level or pulse. There is no back-pressure: a `step` pulse is always taken in the cycle it is seen.

Top module: `dma_addr_step`

## Requirements
- R1: The control readback `cfg_rdata` is 32 bits. Bits 31:16 always read 0, and written values in those bits are discarded. Bits 15:0 hold what was written.
- R2: After reset, `cfg_rdata`, `src_addr` and `dst_addr` are all 0. A cycle with `standby` high clears the control register to 0 at the next edge, and this overrides a write in the same cycle.
- R3: While `mod_standby` is high and `standby` is low, the control register keeps its value and writes are ignored.
- R4: Destination mode is control bits 15:14 and source mode is bits 13:12. The codes are 00 fixed, 01 increment, 10 decrement and 11 reserved. Fixed and reserved leave the address unchanged on a step.
- R5: `xfer_size` codes are 00 byte, 01 word, 10 longword and 11 16-byte. They give step magnitudes of 1, 2, 4 and 16. Increment mode adds the magnitude.
- R6: Decrement mode subtracts the magnitude. For the destination this includes −16 at the 16-byte size.
- R7: At the 16-byte size the source address advances by +16 whatever its mode, including fixed, decrement and reserved, unless R8 holds it.
- R8: With `single_mode` high, `dev_to_mem`=1 holds the destination address on a step, and `dev_to_mem`=0 holds the source address on a step, even at the 16-byte size.
- R9: Addresses are 32-bit and wrap modulo 2^32 on overflow and underflow.
- R10: A step in cycle t is visible after the next clock edge. A load pulse puts its address into the register at the next edge. A load takes priority over a step for that address only, and the other address still steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Clears the control register |
| mod_standby | input | 1 | Freezes the control register |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register readback |
| src_load | input | 1 | Load pulse for the source address |
| src_load_addr | input | 32 | Source start address |
| dst_load | input | 1 | Load pulse for the destination address |
| dst_load_addr | input | 32 | Destination start address |
| xfer_size | input | 2 | Transfer-size code |
| single_mode | input | 1 | Single address mode flag |
| dev_to_mem | input | 1 | 1: external device to memory; 0: memory to device |
| step | input | 1 | One completed transfer unit |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
Two pairs of functions can land in one cycle. The first is an address load arriving with a step. The second is a control write arriving with `standby` or `mod_standby`. Directed cycles raise each pair together on purpose. The random phase also lets them coincide freely. The bench judges every cycle against its own model of the priority rules: a load wins over a step for that address only, and standby wins over a write, which in turn loses to module standby.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;
  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_RSVD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_16B  = 2'b11
  } xfer_size_e;

  localparam int unsigned CTRL_IMPL_W  = 16;
  localparam int unsigned DST_MODE_LSB = 14;
  localparam int unsigned SRC_MODE_LSB = 12;
  localparam int unsigned MAG_W        = 5;

  function automatic logic [MAG_W-1:0] step_mag(input logic [1:0] size);
    case (size)
      SZ_BYTE: step_mag = 5'd1;
      SZ_WORD: step_mag = 5'd2;
      SZ_LONG: step_mag = 5'd4;
      default: step_mag = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned IMPL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              mod_standby,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [IMPL_W-1:0] ctrl,
  output logic [REG_W-1:0]  rdata
);
  localparam int unsigned PAD_W = REG_W - IMPL_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ctrl <= '0;
    else if (standby)     ctrl <= '0;
    else if (mod_standby) ctrl <= ctrl;
    else if (we)          ctrl <= wdata[IMPL_W-1:0];
  end

  assign rdata = {{PAD_W{1'b0}}, ctrl};

  // R1: written low bits appear, high bits discarded
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !standby && !mod_standby) |=> rdata == {{PAD_W{1'b0}}, $past(wdata[IMPL_W-1:0])});
  // R2: standby clears
  assert_standby_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> rdata == '0);
  // R3: module standby freezes
  assert_modstby_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_standby && !standby) |=> $stable(rdata));
endmodule

// File: rtl/dma_step_calc.sv
module dma_step_calc
  import dma_step_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter bit          IS_SRC = 1'b0
) (
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  input  logic          hold,
  output logic [AW-1:0] delta
);
  logic [AW-1:0] mag;
  logic [AW-1:0] by_mode;

  assign mag = AW'(step_mag(size));

  always_comb begin
    case (mode)
      AM_INC:  by_mode = mag;
      AM_DEC:  by_mode = '0 - mag;
      default: by_mode = '0;
    endcase
  end

  generate
    if (IS_SRC) begin : g_src
      always_comb begin
        if (hold)                delta = '0;
        else if (size == SZ_16B) delta = mag;
        else                     delta = by_mode;
      end
    end else begin : g_dst
      always_comb begin
        if (hold) delta = '0;
        else      delta = by_mode;
      end
    end
  endgenerate
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [AW-1:0] delta,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + delta;
  end

  // R10: load wins and lands next edge
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(load_val));
  // R10: nothing moves without a pulse
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr));
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_step_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             mod_standby,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             src_load,
  input  logic [AW-1:0]    src_load_addr,
  input  logic             dst_load,
  input  logic [AW-1:0]    dst_load_addr,
  input  logic [1:0]       xfer_size,
  input  logic             single_mode,
  input  logic             dev_to_mem,
  input  logic             step,
  output logic [AW-1:0]    src_addr,
  output logic [AW-1:0]    dst_addr
);
  localparam int unsigned SIDES = 2;

  logic [CTRL_IMPL_W-1:0] ctrl;
  logic [1:0]             side_mode [SIDES];
  logic                   side_hold [SIDES];
  logic                   side_load [SIDES];
  logic [AW-1:0]          side_lval [SIDES];
  logic [AW-1:0]          side_delta[SIDES];
  logic [AW-1:0]          side_addr [SIDES];

  dma_ctrl_reg #(.REG_W(REG_W), .IMPL_W(CTRL_IMPL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .standby(standby), .mod_standby(mod_standby),
    .we(cfg_we), .wdata(cfg_wdata), .ctrl(ctrl), .rdata(cfg_rdata)
  );

  // side 0 = source, side 1 = destination
  assign side_mode[0] = ctrl[SRC_MODE_LSB +: 2];
  assign side_mode[1] = ctrl[DST_MODE_LSB +: 2];
  assign side_hold[0] = single_mode && !dev_to_mem;
  assign side_hold[1] = single_mode && dev_to_mem;
  assign side_load[0] = src_load;
  assign side_load[1] = dst_load;
  assign side_lval[0] = src_load_addr;
  assign side_lval[1] = dst_load_addr;

  generate
    for (genvar i = 0; i < SIDES; i++) begin : g_side
      dma_step_calc #(.AW(AW), .IS_SRC(i == 0)) u_calc (
        .mode(side_mode[i]), .size(xfer_size), .hold(side_hold[i]),
        .delta(side_delta[i])
      );
      dma_addr_reg #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(side_load[i]), .load_val(side_lval[i]),
        .step(step), .delta(side_delta[i]), .addr(side_addr[i])
      );
    end
  endgenerate

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];

  // R7: 16-byte source always advances by 16
  assert_src_16_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !src_load && xfer_size == SZ_16B && !(single_mode && !dev_to_mem))
      |=> src_addr == $past(src_addr) + AW'(16));
  // R6: destination decrement at 16-byte size
  assert_dst_dec16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dst_load && xfer_size == SZ_16B && cfg_rdata[15:14] == 2'b10
     && !(single_mode && dev_to_mem)) |=> dst_addr == $past(dst_addr) - AW'(16));
  // R8: single mode, device to memory holds destination
  assert_single_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dst_load && single_mode && dev_to_mem) |=> $stable(dst_addr));
endmodule

// File: tb/test_dma_addr_step.sv
`timescale 1ns/1ps
module test_dma_addr_step;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        standby = 0, mod_standby = 0, cfg_we = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        src_load = 0, dst_load = 0;
  logic [31:0] src_load_addr = 0, dst_load_addr = 0;
  logic [1:0]  xfer_size = 0;
  logic        single_mode = 0, dev_to_mem = 0, step = 0;
  logic [31:0] src_addr, dst_addr;

  int total = 0, bad = 0;
  logic [15:0] m_ctrl = 0;
  logic [31:0] m_src = 0, m_dst = 0;

  always #4 clk = ~clk;

  dma_addr_step i_dma_addr_step (
    .clk(clk), .rst_n(rst_n), .standby(standby), .mod_standby(mod_standby),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_load(src_load), .src_load_addr(src_load_addr),
    .dst_load(dst_load), .dst_load_addr(dst_load_addr),
    .xfer_size(xfer_size), .single_mode(single_mode), .dev_to_mem(dev_to_mem),
    .step(step), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  function automatic logic [31:0] mag_of(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 16; endcase
  endfunction

  function automatic logic [31:0] exp_delta(input bit is_src, input logic [1:0] mode,
                                            input logic [1:0] s, input bit hold);
    if (hold) return 0;
    if (is_src && s == 2'd3) return 16;
    if (mode == 2'b01) return mag_of(s);
    if (mode == 2'b10) return 32'd0 - mag_of(s);
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // model update at the clock edge, from inputs stable since the last negedge
  always @(posedge clk) if (rst_n) begin
    logic [31:0] ds, dd;
    ds = exp_delta(1, m_ctrl[13:12], xfer_size, single_mode && !dev_to_mem);
    dd = exp_delta(0, m_ctrl[15:14], xfer_size, single_mode && dev_to_mem);
    if (src_load) m_src <= src_load_addr; else if (step) m_src <= m_src + ds;
    if (dst_load) m_dst <= dst_load_addr; else if (step) m_dst <= m_dst + dd;
    if (standby) m_ctrl <= 0;
    else if (!mod_standby && cfg_we) m_ctrl <= cfg_wdata[15:0];
  end

  task automatic idle();
    standby = 0; mod_standby = 0; cfg_we = 0; src_load = 0; dst_load = 0; step = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    chk("R10 model src", src_addr, m_src);
    chk("R10 model dst", dst_addr, m_dst);
    chk("R1 model ctrl", cfg_rdata, {16'h0, m_ctrl});
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk("R2 reset ctrl", cfg_rdata, 0);
    chk("R2 reset src", src_addr, 0);
    chk("R2 reset dst", dst_addr, 0);
    rst_n = 1;
    @(negedge clk);

    cfg_we = 1; cfg_wdata = 32'hFFFF_5A5A; tick();
    chk("R1 upper discarded", cfg_rdata, 32'h0000_5A5A);
    idle(); mod_standby = 1; cfg_we = 1; cfg_wdata = 32'h0000_1234; tick();
    chk("R3 frozen", cfg_rdata, 32'h0000_5A5A);
    idle(); standby = 1; cfg_we = 1; cfg_wdata = 32'h0000_7777; tick();
    chk("R2 standby clear", cfg_rdata, 0);

    idle(); src_load = 1; src_load_addr = 32'h1000; dst_load = 1; dst_load_addr = 32'h2000;
    cfg_we = 1; cfg_wdata = 32'h0000_6000; tick();
    chk("R10 load src", src_addr, 32'h1000);
    idle(); step = 1; xfer_size = 2'd1; tick();
    chk("R6 src dec word", src_addr, 32'h0FFE);
    chk("R5 dst inc word", dst_addr, 32'h2002);
    idle(); step = 1; src_load = 1; src_load_addr = 32'h50; tick();
    chk("R10 load beats step", src_addr, 32'h50);
    chk("R10 other side steps", dst_addr, 32'h2004);
    idle(); step = 1; xfer_size = 2'd3; tick();
    chk("R7 src dec forced +16", src_addr, 32'h60);
    chk("R5 dst inc 16", dst_addr, 32'h2014);
    idle(); cfg_we = 1; cfg_wdata = 32'h0000_8000; tick();
    idle(); step = 1; tick();
    chk("R7 src fixed forced +16", src_addr, 32'h70);
    chk("R6 dst dec 16", dst_addr, 32'h2004);
    idle(); cfg_we = 1; cfg_wdata = 32'h0000_F000; tick();
    idle(); step = 1; xfer_size = 2'd2; tick();
    chk("R4 reserved src holds", src_addr, 32'h70);
    chk("R4 reserved dst holds", dst_addr, 32'h2004);

    idle(); src_load = 1; src_load_addr = 32'hFFFF_FFF0; dst_load = 1; dst_load_addr = 0;
    cfg_we = 1; cfg_wdata = 32'h0000_9000; tick();
    idle(); step = 1; xfer_size = 2'd3; tick();
    chk("R9 src wrap up", src_addr, 32'h0);
    chk("R9 dst wrap down", dst_addr, 32'hFFFF_FFF0);
    idle(); dst_load = 1; dst_load_addr = 0; tick();
    idle(); step = 1; xfer_size = 2'd0; tick();
    chk("R9 dst byte wrap", dst_addr, 32'hFFFF_FFFF);

    idle(); src_load = 1; src_load_addr = 32'h100; dst_load = 1; dst_load_addr = 32'h200;
    cfg_we = 1; cfg_wdata = 32'h0000_5000; tick();
    idle(); step = 1; single_mode = 1; dev_to_mem = 1; xfer_size = 2'd2; tick();
    chk("R8 dst held", dst_addr, 32'h200);
    chk("R5 src inc long", src_addr, 32'h104);
    idle(); step = 1; dev_to_mem = 0; xfer_size = 2'd3; tick();
    chk("R8 src held 16B", src_addr, 32'h104);
    chk("R5 dst inc 16", dst_addr, 32'h210);
    idle(); single_mode = 0;

    for (int n = 0; n < 3000; n++) begin
      standby       = ($urandom % 40) == 0;
      mod_standby   = ($urandom % 10) == 0;
      cfg_we        = ($urandom % 5) == 0;
      cfg_wdata     = $urandom;
      src_load      = ($urandom % 25) == 0;
      dst_load      = ($urandom % 25) == 0;
      src_load_addr = ($urandom % 4 == 0) ? 32'hFFFF_FFF8 + ($urandom % 8) : $urandom;
      dst_load_addr = ($urandom % 4 == 0) ? ($urandom % 8) : $urandom;
      xfer_size     = 2'($urandom);
      single_mode   = ($urandom % 4) == 0;
      dev_to_mem    = 1'($urandom);
      step          = ($urandom % 2) == 0;
      tick();
    end
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule